// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fetches a board's power-up configuration from a three-wire serial EEPROM organised as 16-bit words. It drives the chip-select, clock and data-in pins itself and samples the device's data-out pin. The serial clock is made by dividing the system clock, and each half-period is a parameter. A pulse on `start` begins a load. The loader does not need to be told how many address bits the EEPROM expects. It first issues a probing read with up to eight address bits. It watches for the low "dummy" bit that the device drives once it has received a full address, and takes the number of bits sent so far as the address width. It then repeats that first read with the learned width and goes on to read every configuration word in ascending order.

While the words stream in, the loader adds their bytes into an 8-bit sum and keeps the three words that hold the 48-bit station address. At the end it pulses `done` and reports one of three outcomes: the contents are valid, the checksum is wrong, or no address width could be found. The station address is presented only when the contents are valid. Writing and erasing the EEPROM are not supported.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `cfg_valid`, `cksum_err`, `size_err`, `addr_width` and `station_addr` are all zero.
- R2: A high `start` while idle begins a load: `busy` rises on the next clock and the three outcome flags clear. A `start` seen while a load is in progress has no effect on the command sequence or the outcome.
- R3: Every read command raises `ee_cs` first and then presents the opcode bits 1, 1, 0 on `ee_di`, MSB first, one bit per `ee_sk` rising edge.
- R4: The first command of a load sends the 8-bit address 0 MSB first. After the high phase of each address clock, `ee_do` is sampled. A low sample stops the address and sets the width to 8 minus the number of address bits not yet sent.
- R5: After the probing command, the loader reads words 0 up to `NWORDS-1` (default 13) in ascending order, each with exactly the learned number of address bits. The probing command's data is discarded.
- R6: Each command ends with 16 data clocks. During these `ee_di` is held low and `ee_do` is sampled at the end of each high phase, giving the word MSB first.
- R7: Every `ee_sk` high phase lasts exactly `HALF_CYC` clocks. Every low phase inside a command lasts at least `HALF_CYC` clocks. `ee_cs` stays low for at least `HALF_CYC` clocks between commands, and `ee_sk` is never high while `ee_cs` is low.
- R8: The low and high bytes of all words read are summed modulo 256. A sum of zero ends the load with `cfg_valid` set; any other sum ends it with `cksum_err` set.
- R9: `station_addr[15:0]` holds word 12, `[31:16]` holds word 11 and `[47:32]` holds word 10. The low byte of each word is the earlier address byte. The output is zero unless `cfg_valid` is set.
- R10: If `ee_do` is still high after the eighth probing address bit, the load stops with `ee_cs` low and `size_err` set, and no further command is sent.
- R11: `done` is a single-cycle pulse, and `busy` is low in that cycle. A `start` given in the cycle where `done` is high is accepted.
- R12: `addr_width` shows the learned address width from the end of the probing command until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load when idle |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| cfg_valid | output | 1 | Last load completed with a zero checksum |
| cksum_err | output | 1 | Last load completed with a non-zero checksum |
| size_err | output | 1 | Last load found no dummy zero bit |
| addr_width | output | 4 | Learned EEPROM address width |
| station_addr | output | 48 | Station address words 12, 11, 10 |

## Verification
Two events can land on the same clock. The first is the dummy-zero detection arriving on the eighth probing bit, which is also the cycle in which the loader would otherwise declare a size error. An 8-bit device provokes this, and the check is that the width is 8 with no error flag; a silent device must give the error. The second is a new `start` in the very cycle `done` is pulsed. The bench issues it there and expects `busy` one clock later, followed by a complete second command sequence with the same results.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GAP,
    S_OP,
    S_ADDR,
    S_DATA,
    S_FIN
  } ld_state_t;

  localparam logic [2:0]  READ_OP    = 3'b110;
  localparam int unsigned PROBE_BITS = 8;

  // byte-wise contribution of one word to the modulo-256 sum
  function automatic logic [7:0] word_bytesum(input logic [15:0] w);
    return w[7:0] + w[15:8];
  endfunction

  // address width learned from the count of address bits still unsent
  function automatic logic [3:0] width_from_unsent(input logic [3:0] unsent);
    return 4'(PROBE_BITS) - unsent;
  endfunction

  function automatic logic pick_bit(input logic [15:0] v, input logic [3:0] idx);
    return v[idx];
  endfunction

endpackage

// File: rtl/eecfg_tick.sv
module eecfg_tick #(
  parameter int unsigned HALF_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run || cnt_q == LAST) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/eecfg_store.sv
module eecfg_store #(
  parameter int unsigned NWORDS   = 14,
  parameter int unsigned IDXW     = 4,
  parameter int unsigned MAC_BASE = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [15:0]     wr_data,
  output logic [7:0]      sum,
  output logic [47:0]     station
);
  import eecfg_pkg::*;

  logic [7:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_q <= '0;
    else if (clr)   sum_q <= '0;
    else if (wr_en) sum_q <= sum_q + word_bytesum(wr_data);
  end
  assign sum = sum_q;

  // only the three station-address words are kept
  for (genvar k = 0; k < 3; k++) begin : g_mac
    localparam logic [IDXW-1:0] SLOT = IDXW'(MAC_BASE + 2 - k);
    logic [15:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       w_q <= '0;
      else if (clr)                     w_q <= '0;
      else if (wr_en && wr_idx == SLOT) w_q <= wr_data;
    end
    assign station[16*k +: 16] = w_q;
  end

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NWORDS));

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int unsigned HALF_CYC = 100,
  parameter int unsigned NWORDS   = 14,
  parameter int unsigned MAC_BASE = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic        busy,
  output logic        done,
  output logic        cfg_valid,
  output logic        cksum_err,
  output logic        size_err,
  output logic [3:0]  addr_width,
  output logic [47:0] station_addr
);
  import eecfg_pkg::*;

  localparam int unsigned IDXW = $clog2(NWORDS);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NWORDS - 1);

  ld_state_t       state;
  logic            sk_q, cs_q, di_q;
  logic [3:0]      bitcnt;
  logic [IDXW-1:0] idx;
  logic            probing;
  logic [3:0]      awidth;
  logic [14:0]     shreg;

  // named internal events
  logic        tick, start_go, half_end, dummy_seen, word_end, wr_en;
  logic [3:0]  first_abit;
  logic [15:0] addr16;
  logic [15:0] wr_data;
  logic [7:0]  sum;
  logic [47:0] station;

  assign start_go   = (state == S_IDLE) && start;
  assign half_end   = tick && sk_q;
  assign dummy_seen = half_end && (state == S_ADDR) && probing && !ee_do;
  assign word_end   = half_end && (state == S_DATA) && (bitcnt == 4'd0);
  assign wr_en      = word_end && !probing;
  assign wr_data    = {shreg, ee_do};
  assign addr16     = 16'(idx);
  assign first_abit = probing ? 4'(PROBE_BITS - 1) : (awidth - 4'd1);

  eecfg_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((state != S_IDLE) && (state != S_FIN)),
    .tick (tick)
  );

  eecfg_store #(.NWORDS(NWORDS), .IDXW(IDXW), .MAC_BASE(MAC_BASE)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start_go),
    .wr_en  (wr_en),
    .wr_idx (idx),
    .wr_data(wr_data),
    .sum    (sum),
    .station(station)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sk_q      <= 1'b0;
      cs_q      <= 1'b0;
      di_q      <= 1'b0;
      bitcnt    <= '0;
      idx       <= '0;
      probing   <= 1'b0;
      awidth    <= '0;
      shreg     <= '0;
      done      <= 1'b0;
      cfg_valid <= 1'b0;
      cksum_err <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state     <= S_GAP;
          probing   <= 1'b1;
          idx       <= '0;
          awidth    <= '0;
          cfg_valid <= 1'b0;
          cksum_err <= 1'b0;
          size_err  <= 1'b0;
        end
        S_GAP: if (tick) begin
          cs_q   <= 1'b1;
          state  <= S_OP;
          bitcnt <= 4'd2;
          di_q   <= READ_OP[2];
        end
        S_OP: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q <= 1'b0;
            if (bitcnt == 4'd0) begin
              state  <= S_ADDR;
              bitcnt <= first_abit;
              di_q   <= pick_bit(addr16, first_abit);
            end else begin
              bitcnt <= bitcnt - 4'd1;
              di_q   <= pick_bit(16'(READ_OP), bitcnt - 4'd1);
            end
          end
        end
        S_ADDR: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q <= 1'b0;
            if (dummy_seen) begin
              awidth <= width_from_unsent(bitcnt);
              state  <= S_DATA;
              bitcnt <= 4'd15;
              di_q   <= 1'b0;
            end else if (bitcnt == 4'd0) begin
              if (probing) begin
                state    <= S_IDLE;
                cs_q     <= 1'b0;
                di_q     <= 1'b0;
                probing  <= 1'b0;
                size_err <= 1'b1;
                done     <= 1'b1;
              end else begin
                state  <= S_DATA;
                bitcnt <= 4'd15;
                di_q   <= 1'b0;
              end
            end else begin
              bitcnt <= bitcnt - 4'd1;
              di_q   <= pick_bit(addr16, bitcnt - 4'd1);
            end
          end
        end
        S_DATA: if (tick) begin
          if (!sk_q) sk_q <= 1'b1;
          else begin
            sk_q  <= 1'b0;
            shreg <= {shreg[13:0], ee_do};
            if (word_end) begin
              cs_q  <= 1'b0;
              state <= S_GAP;
              if (probing)              probing <= 1'b0;
              else if (idx == LAST_IDX) state   <= S_FIN;
              else                      idx     <= idx + 1'b1;
            end else begin
              bitcnt <= bitcnt - 4'd1;
            end
          end
        end
        S_FIN: begin
          state     <= S_IDLE;
          done      <= 1'b1;
          cfg_valid <= (sum == 8'd0);
          cksum_err <= (sum != 8'd0);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ee_cs        = cs_q;
  assign ee_sk        = sk_q;
  assign ee_di        = di_q;
  assign busy         = (state != S_IDLE);
  assign addr_width   = awidth;
  assign station_addr = cfg_valid ? station : 48'd0;

  // phase-length observer for the serial clock
  logic        sk_seen;
  logic [31:0] ph_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_seen <= 1'b0;
      ph_len  <= '0;
    end else begin
      sk_seen <= ee_sk;
      if (ee_sk != sk_seen)  ph_len <= 32'd1;
      else if (ph_len != '1) ph_len <= ph_len + 32'd1;
    end
  end

  // R7
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  // R7
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk != sk_seen) |-> (ph_len >= 32'(HALF_CYC)));

  // R6
  di_low_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> !ee_di);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({cfg_valid, cksum_err, size_err}) == 1));

  // R4
  width_learned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !size_err) |-> (addr_width != 4'd0));

  // R10
  size_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !ee_cs);

endmodule

// File: tb/sim_eeprom_cfg_loader.sv
module sim_eeprom_cfg_loader;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ee_cs, ee_sk, ee_di, ee_do;
  logic busy, done, cfg_valid, cksum_err, size_err;
  logic [3:0]  addr_width;
  logic [47:0] station_addr;

  always #5 clk = ~clk;

  eeprom_cfg_loader #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .busy(busy), .done(done), .cfg_valid(cfg_valid), .cksum_err(cksum_err),
    .size_err(size_err), .addr_width(addr_width), .station_addr(station_addr)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural serial EEPROM
  int          dev_aw   = 6;
  bit          dev_dead = 1'b0;
  logic [15:0] mem [256];
  logic        do_r = 1'b1;
  int          sk_cnt = 0;
  logic [2:0]  op_seen = '0;
  int          addr_seen = 0;
  int          got_addr[$];

  assign ee_do = do_r;

  always @(posedge ee_cs) begin
    sk_cnt = 0; op_seen = '0; addr_seen = 0; do_r = 1'b1;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    sk_cnt++;
    if (sk_cnt <= 3) begin
      op_seen = {op_seen[1:0], ee_di};
      if (sk_cnt == 3) check(op_seen == 3'b110, "R3 opcode", op_seen, 6);
    end else if (sk_cnt <= 3 + dev_aw) begin
      addr_seen = (addr_seen << 1) | int'(ee_di);
      if (sk_cnt == 3 + dev_aw) begin
        got_addr.push_back(addr_seen);
        if (!dev_dead) do_r = 1'b0;
      end
    end else if (sk_cnt <= 3 + dev_aw + 16) begin
      check(ee_di == 1'b0, "R6 DI low during data", ee_di, 0);
      if (!dev_dead) do_r = mem[addr_seen][15 - (sk_cnt - 4 - dev_aw)];
    end
  end

  // per-clock protocol model
  logic prev_sk = 1'b0, prev_cs = 1'b0;
  int   sk_run = 0, cs_low_run = 0;
  always @(negedge clk) if (rst_n) begin
    if (ee_sk && !ee_cs) check(1'b0, "R7 SK high with CS low", 1, 0);
    if (ee_sk != prev_sk) begin
      if (prev_sk)    check(sk_run == HALF, "R7 high phase length", sk_run, HALF);
      else if (ee_cs) check(sk_run >= HALF, "R7 low phase length", sk_run, HALF);
      sk_run = 1;
    end else sk_run++;
    if (ee_cs && !prev_cs) check(cs_low_run >= HALF, "R7 CS gap", cs_low_run, HALF);
    if (!ee_cs) cs_low_run = prev_cs ? 1 : cs_low_run + 1;
    else        cs_low_run = 0;
    prev_sk = ee_sk;
    prev_cs = ee_cs;
  end

  task automatic fill(input int seed, input bit good);
    int s = 0;
    for (int a = 0; a < 256; a++) mem[a] = 16'((a * 16'h3b1 + seed * 16'h71d) ^ 16'h5a5a);
    for (int w = 0; w < 13; w++) s += int'(mem[w][7:0]) + int'(mem[w][15:8]);
    s += int'(mem[13][7:0]);
    mem[13][15:8] = 8'((256 - (s % 256)) + (good ? 0 : 1));
  endtask

  task automatic wait_done(input bit poke, output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (done) begin start = 1'b0; ok = 1'b1; return; end
      start = (poke && t == 200);
    end
    start = 1'b0;
  endtask

  task automatic run_load(input int aw, input bit dead, input bit good,
                          input bit poke, input bit skip_start, input bit chain);
    int exp_q[$];
    bit ok;
    longint exp_st;
    dev_aw = aw; dev_dead = dead;
    got_addr.delete();
    if (!skip_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check({cfg_valid, cksum_err, size_err} == 3'b000, "R2 flags cleared",
            {cfg_valid, cksum_err, size_err}, 0);
    end
    wait_done(poke, ok);
    if (!ok) begin
      check(1'b0, "R11 watchdog waiting for done", 0, 1);
      return;
    end
    check(busy == 1'b0, "R11 busy low with done", busy, 0);
    exp_q.push_back(0);
    if (!dead) for (int w = 0; w < 14; w++) exp_q.push_back(w);
    check(got_addr.size() == exp_q.size(), "R5 R2 command count", got_addr.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_addr.size(); i++)
      check(got_addr[i] == exp_q[i], "R5 address order", got_addr[i], exp_q[i]);
    if (dead) begin
      check(size_err == 1'b1, "R10 size error flag", size_err, 1);
      check(cfg_valid == 1'b0 && cksum_err == 1'b0, "R10 no other outcome",
            {cfg_valid, cksum_err}, 0);
      check(ee_cs == 1'b0, "R10 CS released", ee_cs, 0);
      check(station_addr == 48'd0, "R9 station hidden", station_addr, 0);
    end else begin
      check(addr_width == 4'(aw), "R4 R12 learned width", addr_width, aw);
      check(size_err == 1'b0, "R4 no size error", size_err, 0);
      check(cfg_valid == good, "R8 valid flag", cfg_valid, good);
      check(cksum_err == !good, "R8 checksum error flag", cksum_err, !good);
      exp_st = good ? longint'({mem[10], mem[11], mem[12]}) : 0;
      check(station_addr == 48'(exp_st), "R9 R6 station address", station_addr, exp_st);
    end
    if (chain) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R11 done is one cycle", done, 0);
    if (chain) check(busy == 1'b1, "R11 start in done cycle accepted", busy, 1);
    else       check(busy == 1'b0, "R2 stays idle after load", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done, cfg_valid, cksum_err, size_err} == 8'd0,
          "R1 control outputs in reset", {ee_cs, ee_sk, ee_di, busy, done}, 0);
    check(addr_width == 4'd0 && station_addr == 48'd0, "R1 data outputs in reset",
          station_addr, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && ee_cs == 1'b0 && addr_width == 4'd0, "R1 idle without start",
          {busy, ee_cs}, 0);

    fill(1, 1'b1); run_load(6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // width 8: dummy zero lands on the last probing bit; start poked mid-load (R2)
    fill(2, 1'b1); run_load(8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    fill(3, 1'b0); run_load(4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    fill(4, 1'b1); run_load(8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    fill(5, 1'b1); run_load(7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_load(7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 global watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule